// File: doc/BRIEF.md
# Interrupt Cascade ID Driver and Comparator

This block links a chain of interrupt controllers through a 3-bit cascade bus. A static role input sets the device as master or slave. The bidirectional bus is split into an input, an output and an output enable, and the pad sits outside this block.

In master role, the block latches the serviced level on the first acknowledge strobe. If the per-level slave-attached mask marks that level, the block drives the level number onto the bus as the slave ID until the sequence-end strobe. If the mask bit is clear, the bus stays released and a flag tells the vector logic that the master supplies the vector itself. When no request is pending at the first acknowledge, the block treats the acknowledge exactly as a request on the highest-numbered level.

In slave role, the block never drives the bus. It compares the bus value, sampled on the first acknowledge strobe, with an ID loaded through a synchronous write port. On a match it raises a registered select that enables vector output on the following acknowledge pulses. The select clears at the sequence end.

Top module: `casc_id_unit`

## Requirements
- R1: While rst_ni is low, cas_oe_o, cas_o, slave_sel_o and master_vec_o are all 0, and the stored slave ID is 0.
- R2: In master role (master_i=1), if ack_first_i is sampled high with req_valid_i=1 and slave_mask_i[win_level_i]=1, then from the next cycle cas_oe_o=1, cas_o equals that level, and master_vec_o=0.
- R3: In master role, if the latched level has its slave_mask_i bit at 0, then from the next cycle cas_oe_o=0, cas_o=0 and master_vec_o=1.
- R4: In master role, an ack_first_i with req_valid_i=0 is handled as a request on level 7 (LEVELS-1). The ID on cas_o and the drive/own-vector choice are identical to a real level-7 request.
- R5: After the first acknowledge, cas_oe_o, cas_o and master_vec_o hold their values until ack_last_i, whatever win_level_i, slave_mask_i or req_valid_i do. On the cycle after ack_last_i they are all 0.
- R6: In slave role (master_i=0), cas_oe_o and cas_o stay 0 at all times, and master_vec_o stays 0.
- R7: In slave role, slave_sel_o becomes 1 on the cycle after ack_first_i if cas_i equalled the stored ID at that edge, and 0 otherwise. It drops to 0 on the cycle after ack_last_i.
- R8: A cycle with id_wr_i=1 stores id_wdata_i as the slave ID. It is used from the next cycle on.
- R9: In master role, slave_sel_o stays 0.
- R10: If ack_first_i and ack_last_i are high in the same cycle, the end strobe wins and all outputs are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | Role: 1 master, 0 slave; static during a sequence |
| id_wr_i | input | 1 | Write strobe for the slave ID |
| id_wdata_i | input | 3 | Slave ID to store |
| slave_mask_i | input | 8 | Per-level flag: a slave is attached to this level |
| req_valid_i | input | 1 | A request is pending at the first acknowledge |
| win_level_i | input | 3 | Winning level from the priority logic |
| ack_first_i | input | 1 | One-cycle strobe for the first acknowledge pulse |
| ack_last_i | input | 1 | One-cycle strobe for the end of the acknowledge sequence |
| cas_i | input | 3 | Cascade bus value from the pad |
| cas_o | output | 3 | Cascade ID driven to the pad |
| cas_oe_o | output | 1 | Cascade pad output enable |
| slave_sel_o | output | 1 | Slave is addressed and supplies the vector |
| master_vec_o | output | 1 | Master supplies the vector itself |

## Verification
The bench checks the spurious acknowledge against both values of the level-7 mask bit. A design that fell back to level 0, or that ignored the mask on this path, would put the wrong ID on the bus or release the bus when a slave owns level 7. Mid-sequence changes to the winning level, the mask and the bus catch a design that drives combinationally instead of from the latched level, because its ID would drift before the sequence ends. Same-cycle start and end strobes, slave ID rewrites just before a compare, and role swaps between sequences catch a wrong strobe priority, a stale ID compare, and a master that leaks a select or a slave that drives the pad.

// File: rtl/casc_pkg.sv
package casc_pkg;
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } casc_role_e;

  typedef struct packed {
    logic       active;
    logic       cascaded;
    logic [2:0] level;
  } casc_seq_t;
endpackage

// File: rtl/casc_id_reg.sv
module casc_id_reg #(
  parameter int ID_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [ID_W-1:0] wdata_i,
  output logic [ID_W-1:0] id_o
);
  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   id_q <= '0;
    else if (wr_i) id_q <= wdata_i;
  end

  assign id_o = id_q;

  assert_id_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> id_o == $past(wdata_i));
  assert_id_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(id_o));
endmodule

// File: rtl/casc_master_drv.sv
module casc_master_drv
  import casc_pkg::*;
#(
  parameter int LEVELS = 8,
  localparam int ID_W = $clog2(LEVELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ack_first_i,
  input  logic              ack_last_i,
  input  logic              req_valid_i,
  input  logic [ID_W-1:0]   win_level_i,
  input  logic [LEVELS-1:0] slave_mask_i,
  output logic              drv_oe_o,
  output logic [ID_W-1:0]   drv_id_o,
  output logic              own_vec_o
);
  localparam logic [ID_W-1:0] SPUR_LEVEL = ID_W'(LEVELS - 1);

  logic [ID_W-1:0] pick_level;
  logic            pick_casc;
  logic            active_q, casc_q;
  logic [ID_W-1:0] level_q;

  // spurious acknowledge looks like the lowest-priority level
  assign pick_level = req_valid_i ? win_level_i : SPUR_LEVEL;

  always_comb begin
    pick_casc = 1'b0;
    for (int i = 0; i < LEVELS; i++)
      if (pick_level == ID_W'(i)) pick_casc = slave_mask_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      casc_q   <= 1'b0;
      level_q  <= '0;
    end else if (ack_last_i) begin
      active_q <= 1'b0;
      casc_q   <= 1'b0;
    end else if (ack_first_i && en_i) begin
      active_q <= 1'b1;
      casc_q   <= pick_casc;
      level_q  <= pick_level;
    end
  end

  assign drv_oe_o  = active_q & casc_q;
  assign drv_id_o  = drv_oe_o ? level_q : '0;
  assign own_vec_o = active_q & ~casc_q;

  assert_oe_vec_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_oe_o && own_vec_o));
  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_last_i |=> !drv_oe_o && !own_vec_o && drv_id_o == '0);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_last_i && !ack_first_i) |=> $stable(drv_id_o) && $stable(drv_oe_o) && $stable(own_vec_o));
  assert_spurious_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ack_first_i && !ack_last_i && !req_valid_i && slave_mask_i[LEVELS-1])
      |=> drv_oe_o && drv_id_o == SPUR_LEVEL);
endmodule

// File: rtl/casc_slave_cmp.sv
module casc_slave_cmp #(
  parameter int ID_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            ack_first_i,
  input  logic            ack_last_i,
  input  logic [ID_W-1:0] cas_i,
  input  logic [ID_W-1:0] id_i,
  output logic            sel_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sel_q <= 1'b0;
    else if (ack_last_i)          sel_q <= 1'b0;
    else if (ack_first_i && en_i) sel_q <= (cas_i == id_i);
  end

  assign sel_o = sel_q;

  assert_sel_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_last_i |=> !sel_o);
  assert_sel_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_o) |-> $past(ack_first_i) && $past(cas_i) == $past(id_i));
endmodule

// File: rtl/casc_id_unit.sv
module casc_id_unit
  import casc_pkg::*;
#(
  parameter int LEVELS = 8,
  localparam int ID_W = $clog2(LEVELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              id_wr_i,
  input  logic [ID_W-1:0]   id_wdata_i,
  input  logic [LEVELS-1:0] slave_mask_i,
  input  logic              req_valid_i,
  input  logic [ID_W-1:0]   win_level_i,
  input  logic              ack_first_i,
  input  logic              ack_last_i,
  input  logic [ID_W-1:0]   cas_i,
  output logic [ID_W-1:0]   cas_o,
  output logic              cas_oe_o,
  output logic              slave_sel_o,
  output logic              master_vec_o
);
  casc_role_e      role;
  logic            is_master;
  logic [ID_W-1:0] slv_id;
  logic            m_oe, m_vec, s_sel;
  logic [ID_W-1:0] m_id;

  assign role      = casc_role_e'(master_i);
  assign is_master = (role == ROLE_MASTER);

  casc_id_reg #(.ID_W(ID_W)) u_id (
    .clk_i, .rst_ni,
    .wr_i   (id_wr_i),
    .wdata_i(id_wdata_i),
    .id_o   (slv_id)
  );

  casc_master_drv #(.LEVELS(LEVELS)) u_mst (
    .clk_i, .rst_ni,
    .en_i        (is_master),
    .ack_first_i,
    .ack_last_i,
    .req_valid_i,
    .win_level_i,
    .slave_mask_i,
    .drv_oe_o    (m_oe),
    .drv_id_o    (m_id),
    .own_vec_o   (m_vec)
  );

  casc_slave_cmp #(.ID_W(ID_W)) u_slv (
    .clk_i, .rst_ni,
    .en_i       (!is_master),
    .ack_first_i,
    .ack_last_i,
    .cas_i,
    .id_i       (slv_id),
    .sel_o      (s_sel)
  );

  assign cas_oe_o     = is_master & m_oe;
  assign cas_o        = is_master ? m_id : '0;
  assign master_vec_o = is_master & m_vec;
  assign slave_sel_o  = !is_master & s_sel;

  assert_slave_no_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !cas_oe_o && cas_o == '0 && !master_vec_o);
  assert_master_no_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> !slave_sel_o);
  assert_both_strobes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_first_i && ack_last_i) |=> !cas_oe_o && !slave_sel_o && !master_vec_o);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!cas_oe_o && !slave_sel_o && !master_vec_o);
    end
  end
endmodule

// File: tb/casc_id_unit_tb.sv
module casc_id_unit_tb_top;
  localparam int LEVELS = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       master_i = 1'b1;
  logic       id_wr_i = 1'b0;
  logic [2:0] id_wdata_i = '0;
  logic [7:0] slave_mask_i = '0;
  logic       req_valid_i = 1'b0;
  logic [2:0] win_level_i = '0;
  logic       ack_first_i = 1'b0;
  logic       ack_last_i = 1'b0;
  logic [2:0] cas_i = '0;
  logic [2:0] cas_o;
  logic       cas_oe_o, slave_sel_o, master_vec_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int exp_id = 0;

  always #10 clk_i = ~clk_i;

  casc_id_unit #(.LEVELS(LEVELS)) dut_i (
    .clk_i, .rst_ni, .master_i, .id_wr_i, .id_wdata_i, .slave_mask_i,
    .req_valid_i, .win_level_i, .ack_first_i, .ack_last_i, .cas_i,
    .cas_o, .cas_oe_o, .slave_sel_o, .master_vec_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_level(input bit rv, input int lvl);
    return rv ? lvl : LEVELS - 1;
  endfunction

  task automatic chk_idle(input string req);
    chk(req, "cas_oe", cas_oe_o, 0);
    chk(req, "cas_o", cas_o, 0);
    chk(req, "master_vec", master_vec_o, 0);
    chk(req, "slave_sel", slave_sel_o, 0);
  endtask

  task automatic chk_master(input string req, input int lvl, input bit casc);
    chk(req, "cas_oe", cas_oe_o, casc);
    chk(req, "cas_o", cas_o, casc ? lvl : 0);
    chk(req, "master_vec", master_vec_o, !casc);
    chk("R9", "slave_sel", slave_sel_o, 0);
  endtask

  task automatic write_id(input int v);
    @(negedge clk_i);
    id_wr_i = 1'b1; id_wdata_i = 3'(v);
    @(negedge clk_i);
    id_wr_i = 1'b0;
    exp_id = v;
  endtask

  // first-ack strobe; outputs are checked at the following negedge
  task automatic pulse_first(input bit rv, input int lvl, input logic [7:0] mask, input int cas);
    req_valid_i = rv; win_level_i = 3'(lvl); slave_mask_i = mask; cas_i = 3'(cas);
    ack_first_i = 1'b1;
    @(negedge clk_i);
    ack_first_i = 1'b0;
  endtask

  task automatic pulse_last();
    ack_last_i = 1'b1;
    @(negedge clk_i);
    ack_last_i = 1'b0;
  endtask

  task automatic master_seq(input string req, input bit rv, input int lvl, input logic [7:0] mask);
    int el;
    bit casc;
    el = eff_level(rv, lvl);
    casc = mask[el];
    pulse_first(rv, lvl, mask, $urandom_range(0, 7));
    chk_master(req, el, casc);
    for (int k = 0; k < 2; k++) begin
      win_level_i = 3'($urandom_range(0, 7));
      slave_mask_i = 8'($urandom);
      req_valid_i = 1'($urandom);
      @(negedge clk_i);
      chk_master("R5", el, casc);
    end
    pulse_last();
    chk_idle("R5");
  endtask

  task automatic slave_seq(input string req, input int cas);
    bit hit;
    hit = (cas == exp_id);
    pulse_first(1'($urandom), $urandom_range(0, 7), 8'($urandom), cas);
    chk(req, "slave_sel", slave_sel_o, hit);
    chk("R6", "cas_oe", cas_oe_o, 0);
    chk("R6", "cas_o", cas_o, 0);
    chk("R6", "master_vec", master_vec_o, 0);
    cas_i = 3'($urandom_range(0, 7));
    @(negedge clk_i);
    chk("R7", "slave_sel hold", slave_sel_o, hit);
    pulse_last();
    chk_idle("R7");
  endtask

  initial begin
    process::self().srandom(32'h1c2d3e4f);
    repeat (2) @(negedge clk_i);
    chk_idle("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");
    // reset ID is 0: slave role compares against 0
    master_i = 1'b0;
    @(negedge clk_i);
    slave_seq("R1", 0);
    master_i = 1'b1;
    @(negedge clk_i);

    master_seq("R2", 1'b1, 3, 8'b0000_1000);
    master_seq("R2", 1'b1, 0, 8'b0000_0001);
    master_seq("R3", 1'b1, 5, 8'b1101_1111);
    master_seq("R4", 1'b0, 2, 8'b1000_0000);
    master_seq("R4", 1'b0, 7, 8'b0111_1111);
    master_seq("R4", 1'b1, 7, 8'b1000_0000);

    // same-cycle strobes, master
    req_valid_i = 1'b1; win_level_i = 3'd4; slave_mask_i = 8'hff;
    ack_first_i = 1'b1; ack_last_i = 1'b1;
    @(negedge clk_i);
    ack_first_i = 1'b0; ack_last_i = 1'b0;
    chk_idle("R10");

    master_i = 1'b0;
    @(negedge clk_i);
    write_id(5);
    slave_seq("R8", 5);
    slave_seq("R7", 4);
    write_id(2);
    slave_seq("R8", 5);
    slave_seq("R8", 2);

    // same-cycle strobes, slave, matching bus
    cas_i = 3'(exp_id);
    ack_first_i = 1'b1; ack_last_i = 1'b1;
    @(negedge clk_i);
    ack_first_i = 1'b0; ack_last_i = 1'b0;
    chk_idle("R10");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int pick;
      master_i = 1'($urandom);
      @(negedge clk_i);
      if ($urandom_range(0, 3) == 0) write_id($urandom_range(0, 7));
      if (master_i) begin
        master_seq("R2", 1'($urandom_range(0, 3) != 0), $urandom_range(0, 7), 8'($urandom));
      end else begin
        pick = ($urandom_range(0, 1) == 1) ? exp_id : $urandom_range(0, 7);
        slave_seq("R7", pick);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule